// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address stream for a processor-style synchronous SRAM port. An access opens when one of two active-low address strobes is sampled low: a processor-side strobe or a controller-side strobe. The external address is then captured. For the beats that follow, only the two lowest address bits change. Each change is requested by an active-low advance input. The order is linear (add one, modulo four) or interleaved (start value XOR beat count). The mode input, sampled when the burst opens, picks the order.

On every clock edge the block also sorts the cycle into one of five kinds. It then registers that kind, a valid flag and a write flag beside the address it produces. The three chip enables qualify each strobe in a different way. The processor strobe counts only while enable 1 is low. A processor-strobe start is always a read. A controller-strobe start is a read or a write, as the write control selects. The memory array and the data paths are outside the block.

All outputs are registered and change one edge after the inputs that cause them. The outputs are plain per-cycle control information. There is no valid/ready handshake and no back-pressure: a consumer must take the address and the cycle kind in the cycle they appear.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `cyc_type` is 0 (idle), `cyc_valid` and `wr_out` are 0 and `addr_out` is all zeros. Reset is asynchronous.
- R2: If `strb_cpu_n` is low while `en1_n`=0, `en2`=1 and `en3_n`=0, the next outputs are `cyc_type`=2 (start), `cyc_valid`=1, `wr_out`=0 and `addr_out` equal to `addr_in`. This holds whatever `wr_n` and `strb_ctl_n` are.
- R3: While `en1_n` is high, `strb_cpu_n` is ignored. The cycle is then a deselect (`cyc_type`=1) only if `strb_ctl_n` is low. Otherwise it is decoded as a continuation or a suspension.
- R4: If `strb_ctl_n` is low, the processor strobe is not taken, and the enables are 0,1,0, the cycle is a start (`cyc_type`=2) from `addr_in`, with `wr_out` equal to the inverse of `wr_n`.
- R5: A cycle on a taken strobe with any enable combination other than `en1_n`=0, `en2`=1, `en3_n`=0 is a deselect: `cyc_type`=1, `cyc_valid`=0, `wr_out`=0, and `addr_out` keeps its value. A deselect closes the open burst.
- R6: In linear order (mode 0 at start), each advancing beat adds one, modulo 4, to `addr_out[1:0]`.
- R7: In interleaved order (mode 1 at start), `addr_out[1:0]` equals the start low bits XOR the beat count 0,1,2,3.
- R8: With both strobes not taken and `adv_n` low during an open burst, the cycle is a continuation (`cyc_type`=3) to the next address in the sequence, whatever the enables are. After four beats the sequence wraps to the start value and keeps going. `wr_out` is the inverse of `wr_n`.
- R9: With both strobes not taken and `adv_n` high during an open burst, the cycle is a suspension (`cyc_type`=4): `addr_out` is unchanged and `cyc_valid`=1.
- R10: `addr_out[17:2]` stays constant for the whole burst, including when the low bits wrap.
- R11: The order mode is captured when a burst starts. Changing `order_il` during the burst has no effect on the sequence.
- R12: A continuation or suspension decoded while no burst is open (after reset or after a deselect) gives `cyc_type`=0, `cyc_valid`=0, `wr_out`=0 and an unchanged `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 18 | External start address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Chip enable 1, active low |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| wr_n | input | 1 | Combined write control, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | 18 | Current burst address |
| cyc_type | output | 3 | Cycle kind: 0 idle, 1 deselect, 2 start, 3 continue, 4 suspend |
| cyc_valid | output | 1 | Cycle carries a valid address |
| wr_out | output | 1 | Cycle is a write |

## Verification
Two decisions can fall in the same cycle.

- Both strobes low together. The bench drives both strobes low in one cycle with the write control asserted. It expects a read start from the new address, because the processor strobe has priority.
- A strobe sampled while a burst is open. The bench drives the processor strobe low with enable 1 high while a burst is running. It judges that this decodes as a continuation that ignores both the strobe and the new address. The same pattern with the controller strobe low must give a deselect.

Flipping the order pin and the enables in the middle of a burst checks that continuation beats depend on neither.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_DESEL = 3'd1,
    CYC_START = 3'd2,
    CYC_CONT  = 3'd3,
    CYC_SUSP  = 3'd4
  } cyc_e;

  // Low address bits for a given beat: linear adds, interleaved XORs.
  function automatic logic [1:0] seq_lo2(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/burst_cycle_decode.sv
`timescale 1ns/1ps
module burst_cycle_decode
  import burst_seq_pkg::*;
(
  input  logic strb_cpu_n,
  input  logic strb_ctl_n,
  input  logic adv_n,
  input  logic en1_n,
  input  logic en2,
  input  logic en3_n,
  input  logic wr_n,
  output cyc_e kind,
  output logic kind_wr
);

  logic selected;
  logic cpu_taken;

  assign selected  = !en1_n && en2 && !en3_n;
  // The processor strobe only counts while enable 1 is low.
  assign cpu_taken = !strb_cpu_n && !en1_n;

  always_comb begin
    kind    = CYC_IDLE;
    kind_wr = 1'b0;
    if (cpu_taken) begin
      kind    = selected ? CYC_START : CYC_DESEL;
      kind_wr = 1'b0;
    end else if (!strb_ctl_n) begin
      kind    = selected ? CYC_START : CYC_DESEL;
      kind_wr = selected && !wr_n;
    end else begin
      kind    = adv_n ? CYC_SUSP : CYC_CONT;
      kind_wr = !wr_n;
    end
  end

endmodule

// File: rtl/burst_beat_counter.sv
`timescale 1ns/1ps
module burst_beat_counter
  import burst_seq_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          order_il,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);

  localparam int BW = 2;
  localparam int UW = AW - BW;

  logic [UW-1:0] upper_q;
  logic [BW-1:0] start_q;
  logic [BW-1:0] beat_q;
  logic          il_q;
  logic [BW-1:0] lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      il_q    <= 1'b0;
    end else if (load) begin
      upper_q <= addr_in[AW-1:BW];
      start_q <= addr_in[BW-1:0];
      beat_q  <= '0;
      il_q    <= order_il;
    end else if (step) begin
      beat_q  <= beat_q + BW'(1);
    end
  end

  assign lo       = seq_lo2(start_q, beat_q, il_q);
  assign addr_out = {upper_q, lo};

  // R6: in linear order every step adds one to the low bits, with wrap
  p_lin_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !il_q) |=> (addr_out[BW-1:0] == BW'($past(addr_out[BW-1:0]) + BW'(1))));

  // R10: a step never touches the upper address bits
  p_upper_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(addr_out[AW-1:BW]));

endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  input  logic          wr_n,
  input  logic          order_il,
  output logic [AW-1:0] addr_out,
  output logic [2:0]    cyc_type,
  output logic          cyc_valid,
  output logic          wr_out
);

  localparam int BW = 2;

  cyc_e kind;
  logic kind_wr;
  cyc_e eff_kind;
  logic eff_wr;
  logic open_q;
  cyc_e cyc_q;
  logic wr_q;
  logic do_load, do_step;

  burst_cycle_decode u_dec (
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .en1_n      (en1_n),
    .en2        (en2),
    .en3_n      (en3_n),
    .wr_n       (wr_n),
    .kind       (kind),
    .kind_wr    (kind_wr)
  );

  // Continue/suspend with no open burst collapses to idle.
  always_comb begin
    eff_kind = kind;
    eff_wr   = kind_wr;
    if ((kind == CYC_CONT || kind == CYC_SUSP) && !open_q) begin
      eff_kind = CYC_IDLE;
      eff_wr   = 1'b0;
    end
  end

  assign do_load = (eff_kind == CYC_START);
  assign do_step = (eff_kind == CYC_CONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cyc_q  <= CYC_IDLE;
      wr_q   <= 1'b0;
    end else begin
      cyc_q <= eff_kind;
      wr_q  <= eff_wr;
      if (eff_kind == CYC_START)      open_q <= 1'b1;
      else if (eff_kind == CYC_DESEL) open_q <= 1'b0;
    end
  end

  burst_beat_counter #(.AW(AW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (do_load),
    .step     (do_step),
    .order_il (order_il),
    .addr_in  (addr_in),
    .addr_out (addr_out)
  );

  assign cyc_type  = cyc_q;
  assign cyc_valid = (cyc_q == CYC_START) || (cyc_q == CYC_CONT) || (cyc_q == CYC_SUSP);
  assign wr_out    = wr_q;

  // R2: a selected processor strobe always opens a read burst from addr_in
  p_cpu_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !en1_n && en2 && !en3_n)
      |=> (cyc_type == 3'd2 && !wr_out && addr_out == $past(addr_in)));

  // R5: a taken strobe without full select gives a deselect
  p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_ctl_n && (strb_cpu_n || en1_n) && !(!en1_n && en2 && !en3_n))
      |=> (cyc_type == 3'd1 && !wr_out && $stable(addr_out)));

  // R9: a suspension repeats the previous address
  p_susp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd4) |-> $stable(addr_out));

  // R10: upper bits do not move on continuation or suspension
  p_upper_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd3 || cyc_type == 3'd4) |-> $stable(addr_out[AW-1:BW]));

  // R12: an idle cycle neither writes nor moves the address
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_type == 3'd0) |-> (!wr_out && $stable(addr_out)));

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

  localparam int AW = 18;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strb_cpu_n, strb_ctl_n, adv_n, en1_n, en2, en3_n, wr_n, order_il;
  logic [AW-1:0] addr_out;
  logic [2:0]    cyc_type;
  logic          cyc_valid, wr_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .wr_n(wr_n), .order_il(order_il),
    .addr_out(addr_out), .cyc_type(cyc_type), .cyc_valid(cyc_valid), .wr_out(wr_out)
  );

  // Vector layout: [48]cpu [47]ctl [46]adv [45]e1 [44]e2 [43]e3 [42]wr [41]il
  // [40:23]addr [22:20]exp type [19]exp valid [18]exp wr [17:0]exp addr
  function automatic logic [48:0] v(input logic cpu, ctl, adv, e1, e2, e3, wr, il,
                                    input logic [17:0] a, input logic [2:0] t,
                                    input logic ev, ew, input logic [17:0] ea);
    return {cpu, ctl, adv, e1, e2, e3, wr, il, a, t, ev, ew, ea};
  endfunction

  localparam logic [48:0] TBL [NV] = '{
    v(0,1,0,0,1,0,0,0,18'h2A5C6, 3'd2,1,0,18'h2A5C6),
    v(1,1,0,0,1,0,1,0,18'h00000, 3'd3,1,0,18'h2A5C7),
    v(1,1,0,0,1,0,1,1,18'h00000, 3'd3,1,0,18'h2A5C4),
    v(1,1,1,0,1,0,1,1,18'h00000, 3'd4,1,0,18'h2A5C4),
    v(1,1,0,1,0,1,1,0,18'h00000, 3'd3,1,0,18'h2A5C5),
    v(1,1,0,0,1,0,0,0,18'h00000, 3'd3,1,1,18'h2A5C6),
    v(1,0,1,0,1,0,0,1,18'h0F3D1, 3'd2,1,1,18'h0F3D1),
    v(1,1,0,0,1,0,0,1,18'h00000, 3'd3,1,1,18'h0F3D0),
    v(1,1,0,0,1,0,1,0,18'h00000, 3'd3,1,0,18'h0F3D3),
    v(1,1,0,0,1,0,1,0,18'h00000, 3'd3,1,0,18'h0F3D2),
    v(1,1,0,0,1,0,1,0,18'h00000, 3'd3,1,0,18'h0F3D1),
    v(0,1,0,1,1,0,1,0,18'h3FFFF, 3'd3,1,0,18'h0F3D0),
    v(0,0,0,1,1,0,0,0,18'h3FFFF, 3'd1,0,0,18'h0F3D0),
    v(1,1,0,0,1,0,0,0,18'h00000, 3'd0,0,0,18'h0F3D0),
    v(1,0,0,0,0,0,0,0,18'h11111, 3'd1,0,0,18'h0F3D0),
    v(0,1,0,0,1,1,1,0,18'h11111, 3'd1,0,0,18'h0F3D0),
    v(1,0,1,0,1,0,1,0,18'h00003, 3'd2,1,0,18'h00003),
    v(1,1,0,0,1,0,1,1,18'h00000, 3'd3,1,0,18'h00000),
    v(0,0,0,0,1,0,0,1,18'h3FFFC, 3'd2,1,0,18'h3FFFC)
  };

  function automatic string tag(input int i);
    case (i)
      0, 18:     return "R2 cpu strobe read start";
      1:         return "R6 linear step";
      2, 8:      return "R11 order pin change mid-burst";
      3:         return "R9 suspend holds address";
      4, 5, 10:  return "R8 continue and wrap";
      6, 16:     return "R4 controller strobe start";
      7, 9:      return "R7 interleaved step";
      11, 12:    return "R3 cpu strobe ignored with enable 1 high";
      13:        return "R12 continue with no open burst";
      14, 15:    return "R5 partial select deselect";
      default:   return "R10 upper bits fixed across wrap";
    endcase
  endfunction

  task automatic drive(input logic [48:0] e);
    strb_cpu_n = e[48]; strb_ctl_n = e[47]; adv_n = e[46];
    en1_n = e[45]; en2 = e[44]; en3_n = e[43]; wr_n = e[42]; order_il = e[41];
    addr_in = e[40:23];
  endtask

  task automatic cmp(input string rq, input logic [2:0] et, input logic ev,
                     input logic ew, input logic [17:0] ea);
    n_vec++;
    if (cyc_type !== et || cyc_valid !== ev || wr_out !== ew || addr_out !== ea) begin
      n_bad++;
      $display("FAIL %s: got type=%0d valid=%0b wr=%0b addr=%h, expected type=%0d valid=%0b wr=%0b addr=%h",
               rq, cyc_type, cyc_valid, wr_out, addr_out, et, ev, ew, ea);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    drive(v(1,1,1,0,1,0,1,0,18'h00000, 3'd0,0,0,18'h0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 reset state", 3'd0, 1'b0, 1'b0, 18'h0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    cmp("R12 suspend after reset is idle", 3'd0, 1'b0, 1'b0, 18'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      @(posedge clk); #2;
      cmp(tag(i), TBL[i][22:20], TBL[i][19], TBL[i][18], TBL[i][17:0]);
    end

    // R1: reset in the middle of a burst clears everything at once
    @(negedge clk);
    drive(v(0,1,0,0,1,0,1,0,18'h15555, 3'd0,0,0,18'h0));
    @(posedge clk); #2;
    cmp("R2 start before mid-burst reset", 3'd2, 1'b1, 1'b0, 18'h15555);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    cmp("R1 asynchronous reset mid-burst", 3'd0, 1'b0, 1'b0, 18'h0);
    drive(v(1,1,0,0,1,0,0,0,18'h00000, 3'd0,0,0,18'h0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    cmp("R12 continue after reset is idle", 3'd0, 1'b0, 1'b0, 18'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion within 5000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule